// File: doc/BRIEF.md
# Strided Gap-Skipping Copy Engine

The engine copies a programmed number of bytes from a source region to a destination region. Both regions are laid out as lines separated by gaps. The source and the destination each have their own line width and gap size, counted in 16-byte units. The engine walks the source in 16-byte beats. When a source line is used up it skips the source gap, and when a destination line is filled it skips the destination gap. The two line boundaries advance independently of each other, so data can be reshaped from one pitch to another in a single pass.

Software sets the configuration inputs and pulses `start`. Each cycle the engine issues one beat: a read address with its data returned combinationally, and a write of that data with byte enables. Only the final beat of a copy whose size is not a multiple of 16 writes a partial set of bytes. A copy with zero source width, zero destination width or zero size is refused with a one-cycle `reject` pulse. A copy that runs to completion ends with a one-cycle `done` pulse.

Top module: `strided_copy`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `reject`, `rd_en` and `wr_en` are all low.
- R2: A start sampled while idle with `cfg_src_width`, `cfg_dst_width` or `cfg_size` equal to zero raises `reject` for exactly the next cycle. No beat is issued and `busy` stays low.
- R3: A start sampled while idle with all three of those fields non-zero raises `busy` in the next cycle. The engine then issues one beat per cycle (`rd_en` and `wr_en` high together), ceil(`cfg_size`/16) beats in total, with no idle cycle between them.
- R4: Source beat addresses (16-byte units) start at `cfg_src_base` and go up by one per beat. After every `cfg_src_width` beats, the next address also skips `cfg_src_gap` units.
- R5: Destination beat addresses start at `cfg_dst_base` and go up by one per beat. After every `cfg_dst_width` beats, the next address also skips `cfg_dst_gap` units, independently of the source line position.
- R6: `wr_data` equals `rd_data` in the same cycle. `wr_be` bit i enables byte i (bits 8i+7:8i). Every beat has `wr_be` = 16'hFFFF, except the last beat when `cfg_size` mod 16 = n > 0, which has only the low n bits set.
- R7: `done` is high for exactly the one cycle after the last beat. `busy` is low in that cycle.
- R8: While `busy` is high, `start` is ignored, and changes to any configuration input have no effect on the copy in progress.
- R9: A start sampled in the `done` cycle is accepted, so copies can run back to back with one gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a copy (sampled while idle) |
| cfg_src_base | input | ADDR_W | Source start, 16-byte units |
| cfg_dst_base | input | ADDR_W | Destination start, 16-byte units |
| cfg_src_width | input | FIELD_W | Source line width, 16-byte units |
| cfg_src_gap | input | FIELD_W | Source gap, 16-byte units |
| cfg_dst_width | input | FIELD_W | Destination line width, 16-byte units |
| cfg_dst_gap | input | FIELD_W | Destination gap, 16-byte units |
| cfg_size | input | SIZE_W | Total bytes to copy |
| rd_en | output | 1 | Source read strobe |
| rd_addr | output | ADDR_W | Source beat address |
| rd_data | input | 128 | Source data, valid in the same cycle |
| wr_en | output | 1 | Destination write strobe |
| wr_addr | output | ADDR_W | Destination beat address |
| wr_data | output | 128 | Destination data |
| wr_be | output | 16 | Destination byte enables |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| reject | output | 1 | One-cycle refusal pulse |

## Verification
Wrong internal state shows up at the ports within one beat. A line counter that is off by one moves the gap skip on `rd_addr` or `wr_addr` to the wrong beat. A remaining-byte count that is wrong shifts the `busy` fall, the `done` pulse or the partial `wr_be` to the wrong cycle. A reference model replays the same copy in chunks bounded by three remaining counts. It predicts every beat's source address, destination address and enables, and compares them in every cycle. Configuration is scrambled during copies, and starts are issued while busy, so any leak of live inputs into a running copy is also seen at the next beat.

// File: rtl/strided_copy.sv
module strided_copy #(
  parameter int ADDR_W  = 20,
  parameter int FIELD_W = 12,
  parameter int SIZE_W  = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  cfg_src_base,
  input  logic [ADDR_W-1:0]  cfg_dst_base,
  input  logic [FIELD_W-1:0] cfg_src_width,
  input  logic [FIELD_W-1:0] cfg_src_gap,
  input  logic [FIELD_W-1:0] cfg_dst_width,
  input  logic [FIELD_W-1:0] cfg_dst_gap,
  input  logic [SIZE_W-1:0]  cfg_size,
  output logic               rd_en,
  output logic [ADDR_W-1:0]  rd_addr,
  input  logic [127:0]       rd_data,
  output logic               wr_en,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [127:0]       wr_data,
  output logic [15:0]        wr_be,
  output logic               busy,
  output logic               done,
  output logic               reject
);
  localparam int BEAT = 16;

  logic               run_q, done_q, rej_q;
  logic [ADDR_W-1:0]  sp_q, dp_q;
  logic [FIELD_W-1:0] sw_q, sg_q, dw_q, dg_q, sl_q, dl_q;
  logic [SIZE_W-1:0]  left_q;

  logic last, bad, go;
  assign last = left_q <= SIZE_W'(BEAT);
  assign bad  = (cfg_src_width == '0) || (cfg_dst_width == '0) || (cfg_size == '0);
  assign go   = start && !run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0; done_q <= 1'b0; rej_q <= 1'b0;
      sp_q <= '0; dp_q <= '0; left_q <= '0;
      sw_q <= '0; sg_q <= '0; dw_q <= '0; dg_q <= '0; sl_q <= '0; dl_q <= '0;
    end else begin
      done_q <= run_q && last;
      rej_q  <= go && bad;
      if (go && !bad) begin
        run_q  <= 1'b1;
        sp_q   <= cfg_src_base;  dp_q <= cfg_dst_base;
        sw_q   <= cfg_src_width; sg_q <= cfg_src_gap;
        dw_q   <= cfg_dst_width; dg_q <= cfg_dst_gap;
        sl_q   <= cfg_src_width; dl_q <= cfg_dst_width;
        left_q <= cfg_size;
      end else if (run_q) begin
        if (last) begin
          run_q  <= 1'b0;
          left_q <= '0;
        end else begin
          left_q <= left_q - SIZE_W'(BEAT);
        end
        if (sl_q == FIELD_W'(1)) begin
          sl_q <= sw_q;
          sp_q <= sp_q + ADDR_W'(sg_q) + ADDR_W'(1);
        end else begin
          sl_q <= sl_q - FIELD_W'(1);
          sp_q <= sp_q + ADDR_W'(1);
        end
        if (dl_q == FIELD_W'(1)) begin
          dl_q <= dw_q;
          dp_q <= dp_q + ADDR_W'(dg_q) + ADDR_W'(1);
        end else begin
          dl_q <= dl_q - FIELD_W'(1);
          dp_q <= dp_q + ADDR_W'(1);
        end
      end
    end
  end

  assign rd_en   = run_q;
  assign wr_en   = run_q;
  assign rd_addr = sp_q;
  assign wr_addr = dp_q;
  assign wr_data = rd_data;
  assign wr_be   = (last && left_q[3:0] != 4'd0) ? 16'((17'd1 << left_q[3:0]) - 17'd1) : 16'hFFFF;
  assign busy    = run_q;
  assign done    = done_q;
  assign reject  = rej_q;
endmodule

module strided_copy_chk #(
  parameter int ADDR_W  = 20,
  parameter int FIELD_W = 12,
  parameter int SIZE_W  = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [FIELD_W-1:0] cfg_src_width,
  input logic [FIELD_W-1:0] cfg_dst_width,
  input logic [SIZE_W-1:0]  cfg_size,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [15:0]        wr_be,
  input logic               busy,
  input logic               done,
  input logic               reject
);
  // R2
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!busy && !wr_en && !rd_en));
  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && cfg_src_width != '0 && cfg_dst_width != '0 && cfg_size != '0) |=> busy);
  // R4
  src_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> (rd_addr != $past(rd_addr)));
  // R5
  dst_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr != $past(wr_addr)));
  // R6
  partial_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be != 16'hFFFF) |=> !busy);
  // R7
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !reject);
endmodule

bind strided_copy strided_copy_chk #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .cfg_src_width(cfg_src_width), .cfg_dst_width(cfg_dst_width), .cfg_size(cfg_size),
  .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
  .busy(busy), .done(done), .reject(reject)
);

// File: tb/tb_strided_copy.sv
module tb_strided_copy;
  localparam int AW = 20, FW = 12, SW = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] cfg_src_base = '0, cfg_dst_base = '0;
  logic [FW-1:0] cfg_src_width = '0, cfg_src_gap = '0, cfg_dst_width = '0, cfg_dst_gap = '0;
  logic [SW-1:0] cfg_size = '0;
  logic rd_en, wr_en, busy, done, reject;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [127:0] rd_data, wr_data;
  logic [15:0] wr_be;

  always #5 clk = ~clk;

  function automatic logic [127:0] pat(input logic [AW-1:0] a);
    logic [31:0] w;
    w = {12'h0, a};
    return {w ^ 32'h5A5A_1234, w * 32'd3 + 32'd11, ~w, w + 32'h0700_0007};
  endfunction

  assign rd_data = pat(rd_addr);

  strided_copy #(.ADDR_W(AW), .FIELD_W(FW), .SIZE_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src_base(cfg_src_base), .cfg_dst_base(cfg_dst_base),
    .cfg_src_width(cfg_src_width), .cfg_src_gap(cfg_src_gap),
    .cfg_dst_width(cfg_dst_width), .cfg_dst_gap(cfg_dst_gap), .cfg_size(cfg_size),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .busy(busy), .done(done), .reject(reject)
  );

  typedef struct packed {
    logic bz, en, dn, rj;
    logic [AW-1:0] s, d;
    logic [15:0] be;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  logic cur_busy = 1'b0;
  logic finished = 1'b0;

  always @(negedge clk) begin
    exp_t e;
    logic bad;
    bad = 1'b0;
    if (!rst_n) begin
      vectors++;
      if (busy || done || reject || rd_en || wr_en) begin
        $display("FAIL R1 reset outputs busy=%b done=%b rej=%b en=%b/%b expected all 0",
                 busy, done, reject, rd_en, wr_en);
        bad = 1'b1;
      end
    end else begin
      e = (q.size() != 0) ? q.pop_front() : '0;
      cur_busy = e.bz;
      vectors++;
      if (busy !== e.bz || rd_en !== e.en || wr_en !== e.en) begin
        $display("FAIL R3 busy/rd_en/wr_en actual %b%b%b expected %b%b%b", busy, rd_en, wr_en, e.bz, e.en, e.en);
        bad = 1'b1;
      end
      if (reject !== e.rj) begin
        $display("FAIL R2 reject actual %b expected %b", reject, e.rj);
        bad = 1'b1;
      end
      if (done !== e.dn) begin
        $display("FAIL R7 done actual %b expected %b", done, e.dn);
        bad = 1'b1;
      end
      if (e.en) begin
        if (rd_addr !== e.s) begin
          $display("FAIL R4 rd_addr actual %h expected %h", rd_addr, e.s);
          bad = 1'b1;
        end
        if (wr_addr !== e.d) begin
          $display("FAIL R5 wr_addr actual %h expected %h", wr_addr, e.d);
          bad = 1'b1;
        end
        if (wr_be !== e.be || wr_data !== pat(e.s)) begin
          $display("FAIL R6 be/data actual %h/%h expected %h/%h", wr_be, wr_data, e.be, pat(e.s));
          bad = 1'b1;
        end
      end
    end
    if (bad) miscompares++;
  end

  task automatic launch(input int sb, input int db, input int iw, input int ig,
                        input int ow, input int og, input int sz);
    @(negedge clk); #1;
    start = 1'b1;
    cfg_src_base = AW'(sb); cfg_dst_base = AW'(db);
    cfg_src_width = FW'(iw); cfg_src_gap = FW'(ig);
    cfg_dst_width = FW'(ow); cfg_dst_gap = FW'(og); cfg_size = SW'(sz);
    if (!cur_busy) begin
      if (iw == 0 || ow == 0 || sz == 0) begin
        q.push_back('{bz:1'b0, en:1'b0, dn:1'b0, rj:1'b1, s:'0, d:'0, be:'0});
      end else begin
        int src = sb * 16, dst = db * 16, rem = sz, ri = iw * 16, ro = ow * 16;
        while (rem > 0) begin
          int c;
          c = ri;
          if (ro < c) c = ro;
          if (rem < c) c = rem;
          for (int k = 0; k < c; k += 16) begin
            exp_t e;
            e.bz = 1'b1; e.en = 1'b1; e.dn = 1'b0; e.rj = 1'b0;
            e.s = AW'((src + k) / 16); e.d = AW'((dst + k) / 16);
            e.be = (c - k >= 16) ? 16'hFFFF : 16'((1 << (c - k)) - 1);
            q.push_back(e);
          end
          src += c; dst += c; rem -= c; ri -= c; ro -= c;
          if (ri == 0) begin ri = iw * 16; src += ig * 16; end
          if (ro == 0) begin ro = ow * 16; dst += og * 16; end
        end
        q.push_back('{bz:1'b0, en:1'b0, dn:1'b1, rj:1'b0, s:'0, d:'0, be:'0});
      end
    end
    @(negedge clk); #1;
    start = 1'b0;
  endtask

  task automatic scramble(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      cfg_src_base = AW'($urandom); cfg_dst_base = AW'($urandom);
      cfg_src_width = FW'($urandom); cfg_src_gap = FW'($urandom);
      cfg_dst_width = FW'($urandom); cfg_dst_gap = FW'($urandom);
      cfg_size = SW'($urandom);
    end
  endtask

  task automatic drain();
    while (q.size() != 0 || cur_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R3 R4 R5: source lines of 2 with gap 1, destination lines of 3, no gap
    launch(16, 512, 2, 1, 3, 0, 160); drain();
    // R3: single beat, contiguous
    launch(5, 9, 1, 0, 1, 0, 16); drain();
    // R6: partial last beat (200 mod 16 = 8)
    launch(100, 300, 4, 2, 1, 3, 200); drain();
    // R6: 33 bytes, one-byte last beat
    launch(40, 80, 3, 0, 2, 5, 33); drain();
    // R6: one byte total
    launch(7, 8, 1, 1, 1, 1, 1); drain();
    // R2: each zero field refused
    launch(1, 2, 0, 0, 1, 0, 64); drain();
    launch(1, 2, 1, 0, 0, 0, 64); drain();
    launch(1, 2, 1, 0, 1, 0, 0); drain();
    // R8: start while busy ignored, config scrambled during copy
    launch(200, 600, 3, 1, 2, 2, 256);
    launch(0, 0, 0, 0, 0, 0, 0);
    launch(9, 9, 1, 0, 1, 0, 48);
    scramble(6);
    drain();
    // R9: start sampled in the done cycle is accepted
    launch(50, 70, 2, 0, 5, 1, 96);
    while (q.size() > 1) @(negedge clk);
    launch(60, 90, 1, 2, 2, 0, 70);
    drain();
    // R3 R4 R5: long copy with wide gaps on both sides
    launch(1000, 4000, 7, 9, 5, 13, 1000); drain();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      $display("FAIL watchdog: run did not complete, expected completion");
      miscompares++;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule